// File: doc/BRIEF.md
# Vectored Interrupt Controller

This peripheral collects up to 32 interrupt sources and presents them to a processor through eight 32-bit word registers on a simple register bus. The bus has one address, a write strobe and write data. Read data is a combinational function of the address and the stored state, and a read has no side effect. Each source is fixed at build time as either level-sensitive or rising-edge-sensitive. A detected source is latched into a status register. An enable register masks the status register into a read-only pending view.

Software works with the block in four ways:
- It turns enables on or off in bulk through dedicated set and clear registers.
- It retires status bits by writing ones to an acknowledge register.
- It asks a vector register for the lowest-numbered pending source. The vector register returns all ones when no source is pending.
- It gates the single request output with two master bits.

Top module: `vec_irq_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, the status, pending, enable and master registers read 0, the vector reads 0xFFFFFFFF and `irq_out` is 0.
- R2: A level source (its `EDGE_KIND` bit is 0) sets its status bit one clock after it is sampled high. If the bit is acknowledged while the source is still high, it stays set. It clears only when it is acknowledged while the source is low.
- R3: An edge source (its `EDGE_KIND` bit is 1) sets its status bit one clock after a sampled 0-to-1 transition. The bit stays set after the source falls, until it is acknowledged. A source that stays high does not set the bit again.
- R4: Word offset 0x08 loads the enable register. Offset 0x10 ORs the written mask into it. Offset 0x14 clears the bits written as 1. Bits written as 0 at 0x10 or 0x14 are left unchanged. Offsets 0x0C, 0x10 and 0x14 read as 0.
- R5: Writing a mask to offset 0x0C clears the matching status bits (0xFFFFFFFF clears them all), except where a new detection arrives in the same cycle.
- R6: Offset 0x04 reads status AND enable. Writes to offsets 0x00, 0x04 and 0x18 are ignored.
- R7: Offset 0x18 reads the index of the lowest-numbered pending source, or 0xFFFFFFFF when no source is pending.
- R8: Offset 0x1C holds two bits: bit 0 is the master enable and bit 1 is the hardware request enable. Writing 0x3 reads back 0x3, and bits 31:2 read as 0.
- R9: `irq_out` is 1 exactly when some pending bit is set and both master bits are 1.
- R10: Status, pending and enable bits at positions N_SRC and above always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | N_SRC | Interrupt source lines |
| bus_addr | input | 5 | Byte address of the word register, bits 4:2 select it |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
A status bit that is wrongly held or dropped shows at the ports one clock after the stimulus. It appears at the status and pending offsets, moves the vector, and toggles `irq_out` when the source is enabled. An enable or master bit that is stored wrongly shows on the very next read of its offset, and on `irq_out` in the same cycle. The bench therefore compares the read data and `irq_out` with a behavioural model on every cycle. A fault is caught within one clock of the first stimulus that exposes it.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        SEL_STATUS  = 3'd0,
        SEL_PENDING = 3'd1,
        SEL_ENABLE  = 3'd2,
        SEL_ACK     = 3'd3,
        SEL_SETEN   = 3'd4,
        SEL_CLREN   = 3'd5,
        SEL_VECTOR  = 3'd6,
        SEL_MASTER  = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic hw_en;      // bit 1
        logic master_en;  // bit 0
    } master_t;

    localparam logic [WORD_W-1:0] NO_VECTOR = '1;

    function automatic reg_sel_e decode_sel(input logic [4:0] addr);
        return reg_sel_e'(addr[4:2]);
    endfunction

endpackage

// File: rtl/irqc_sense.sv
module irqc_sense #(
    parameter int          N_SRC     = 32,
    parameter logic [31:0] EDGE_KIND = 32'h0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] src,
    input  logic [N_SRC-1:0] ack,
    output logic [N_SRC-1:0] status
);

    for (genvar i = 0; i < N_SRC; i++) begin : g_bit
        logic hit;

        if (EDGE_KIND[i]) begin : g_edge
            logic prev_q;
            always_ff @(posedge clk) begin
                if (rst) prev_q <= 1'b0;
                else     prev_q <= src[i];
            end
            assign hit = src[i] & ~prev_q;

            p_edge_hold_r3: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(status[i]) && !$past(ack[i])) |-> status[i]);
        end else begin : g_level
            assign hit = src[i];

            p_level_reassert_r2: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(src[i])) |-> status[i]);
        end

        always_ff @(posedge clk) begin
            if (rst) status[i] <= 1'b0;
            else     status[i] <= (status[i] & ~ack[i]) | hit;
        end

        p_ack_clear_r5: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(ack[i]) && !$past(src[i])) |-> !status[i]);
    end

endmodule

// File: rtl/irqc_prio.sv
module irqc_prio
    import irqc_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  pend,
    output logic [WORD_W-1:0] vector
);

    logic              found;
    logic [WORD_W-1:0] idx;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                found = 1'b1;
                idx   = WORD_W'(i);
            end
        end
        vector = found ? idx : NO_VECTOR;
    end

    p_vec_pending_r7: assert property (@(posedge clk) disable iff (rst)
        (vector != NO_VECTOR) |-> pend[vector[4:0]]);

    p_vec_none_r7: assert property (@(posedge clk) disable iff (rst)
        (vector == NO_VECTOR) |-> (pend == '0));

endmodule

// File: rtl/irqc_regfile.sv
module irqc_regfile
    import irqc_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [4:0]        addr,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    input  logic [N_SRC-1:0]  status,
    input  logic [WORD_W-1:0] vector,
    output logic [N_SRC-1:0]  enable,
    output master_t           master,
    output logic [N_SRC-1:0]  ack,
    output logic [WORD_W-1:0] rdata
);

    reg_sel_e         sel;
    logic [N_SRC-1:0] wmask;

    assign sel   = decode_sel(addr);
    assign wmask = wdata[N_SRC-1:0];
    assign ack   = (we && sel == SEL_ACK) ? wmask : '0;

    function automatic logic [WORD_W-1:0] widen(input logic [N_SRC-1:0] v);
        logic [WORD_W-1:0] r;
        r = '0;
        r[N_SRC-1:0] = v;
        return r;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            enable <= '0;
            master <= '0;
        end else if (we) begin
            unique case (sel)
                SEL_ENABLE: enable <= wmask;
                SEL_SETEN:  enable <= enable | wmask;
                SEL_CLREN:  enable <= enable & ~wmask;
                SEL_MASTER: master <= master_t'(wdata[1:0]);
                default:    ;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            SEL_STATUS:  rdata = widen(status);
            SEL_PENDING: rdata = widen(status & enable);
            SEL_ENABLE:  rdata = widen(enable);
            SEL_VECTOR:  rdata = vector;
            SEL_MASTER:  rdata = WORD_W'(master);
            default:     rdata = '0;
        endcase
    end

    p_setena_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(we && sel == SEL_SETEN))
            |-> ((enable & $past(wmask)) == $past(wmask)));

    p_clrena_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(we && sel == SEL_CLREN))
            |-> ((enable & $past(wmask)) == '0));

    p_master_load_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(we && sel == SEL_MASTER))
            |-> (master == $past(wdata[1:0])));

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int          N_SRC     = 32,
    parameter logic [31:0] EDGE_KIND = 32'h0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] irq_src,
    input  logic [4:0]       bus_addr,
    input  logic             bus_we,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic             irq_out
);

    logic [N_SRC-1:0]  status;
    logic [N_SRC-1:0]  enable;
    logic [N_SRC-1:0]  ack;
    logic [N_SRC-1:0]  pend;
    logic [WORD_W-1:0] vector;
    master_t           master;

    irqc_sense #(.N_SRC(N_SRC), .EDGE_KIND(EDGE_KIND)) u_sense (
        .clk    (clk),
        .rst    (rst),
        .src    (irq_src),
        .ack    (ack),
        .status (status)
    );

    assign pend = status & enable;

    irqc_prio #(.N_SRC(N_SRC)) u_prio (
        .clk    (clk),
        .rst    (rst),
        .pend   (pend),
        .vector (vector)
    );

    irqc_regfile #(.N_SRC(N_SRC)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .addr   (bus_addr),
        .we     (bus_we),
        .wdata  (bus_wdata),
        .status (status),
        .vector (vector),
        .enable (enable),
        .master (master),
        .ack    (ack),
        .rdata  (bus_rdata)
    );

    assign irq_out = (|pend) & master.master_en & master.hw_en;

    p_irq_vec_r9: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (vector != NO_VECTOR));

    p_irq_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> !irq_out);

endmodule

// File: tb/vec_irq_ctrl_tb_top.sv
module vec_irq_ctrl_tb_top;

    localparam int          CLK_PERIOD = 10;
    localparam int          N          = 12;
    localparam logic [31:0] KIND       = 32'h0000_00F0;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  src = '0;
    logic [4:0]    addr = '0;
    logic          we = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    // behavioural model state
    logic [31:0] m_stat = '0;
    logic [31:0] m_en   = '0;
    logic [31:0] m_mst  = '0;
    logic [31:0] m_prev = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vec_irq_ctrl #(.N_SRC(N), .EDGE_KIND(KIND)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .irq_src   (src),
        .bus_addr  (addr),
        .bus_we    (we),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq_out   (irq)
    );

    function automatic logic [31:0] lane_mask();
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < N; i++) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic [31:0] m_vector();
        logic [31:0] p;
        p = m_stat & m_en;
        for (int i = 0; i < 32; i++) if (p[i]) return i;
        return 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] m_read(input logic [4:0] a);
        case (a[4:2])
            3'd0:    return m_stat;
            3'd1:    return m_stat & m_en;
            3'd2:    return m_en;
            3'd6:    return m_vector();
            3'd7:    return m_mst;
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_stat = '0; m_en = '0; m_mst = '0; m_prev = '0;
        end else begin
            logic [31:0] ackm;
            logic [31:0] s;
            ackm = (we && addr[4:2] == 3'd3) ? (wdata & lane_mask()) : '0;
            s    = 32'(src);
            for (int i = 0; i < N; i++) begin
                logic hit;
                hit = KIND[i] ? (s[i] && !m_prev[i]) : s[i];
                m_stat[i] = (m_stat[i] && !ackm[i]) || hit;
            end
            m_prev = s;
            if (we) begin
                case (addr[4:2])
                    3'd2: m_en = wdata & lane_mask();
                    3'd4: m_en = m_en | (wdata & lane_mask());
                    3'd5: m_en = m_en & ~wdata;
                    3'd7: m_mst = wdata & 32'h3;
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // one bus cycle: drive at the falling edge, compare shortly after
    task automatic cyc(input string req, input logic [4:0] a, input logic w,
                       input logic [31:0] d, input logic [N-1:0] s);
        logic mirq;
        logic [31:0] p;
        @(negedge clk);
        addr = a; we = w; wdata = d; src = s;
        #1;
        p    = m_stat & m_en;
        mirq = (p != 0) && m_mst[0] && m_mst[1];
        check(req, rdata, m_read(a));
        check("R9", {31'b0, irq}, {31'b0, mirq});
    endtask

    task automatic rd(input string req, input logic [4:0] a, input logic [N-1:0] s);
        cyc(req, a, 1'b0, 32'h0, s);
    endtask

    task automatic wr(input string req, input logic [4:0] a, input logic [31:0] d,
                      input logic [N-1:0] s);
        cyc(req, a, 1'b1, d, s);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        // R1: reset state on every offset
        for (int k = 0; k < 8; k++) rd("R1", 5'(k * 4), 12'hFFF);
        @(negedge clk);
        rst = 1'b0;
        src = '0;
        for (int k = 0; k < 8; k++) rd("R1", 5'(k * 4), '0);

        // R8: master bits
        wr("R8", 5'h1C, 32'hFFFF_FFFF, '0);
        rd("R8", 5'h1C, '0);
        wr("R8", 5'h1C, 32'h3, '0);
        rd("R8", 5'h1C, '0);

        // R4: load, set, clear enables; R10 upper bits
        wr("R4", 5'h10, 32'h0000_000F, '0);
        rd("R4", 5'h08, '0);
        wr("R4", 5'h14, 32'h0000_0005, '0);
        rd("R4", 5'h08, '0);
        rd("R4", 5'h10, '0);
        rd("R4", 5'h14, '0);
        wr("R4", 5'h08, 32'h0000_00FF, '0);
        rd("R4", 5'h08, '0);
        wr("R10", 5'h10, 32'hFFFF_FFFF, '0);
        rd("R10", 5'h08, '0);

        // R2: level source 2, ack while high, then ack while low
        rd("R2", 5'h00, 12'h004);
        rd("R2", 5'h00, 12'h004);
        wr("R2", 5'h0C, 32'h4, 12'h004);
        rd("R2", 5'h00, 12'h004);
        rd("R2", 5'h00, 12'h000);
        wr("R2", 5'h0C, 32'h4, 12'h000);
        rd("R2", 5'h00, 12'h000);

        // R3: edge source 5 held high, fall, ack
        rd("R3", 5'h00, 12'h020);
        rd("R3", 5'h00, 12'h020);
        wr("R3", 5'h0C, 32'h20, 12'h020);
        rd("R3", 5'h00, 12'h020);
        rd("R3", 5'h00, 12'h000);
        rd("R3", 5'h00, 12'h020);
        rd("R3", 5'h00, 12'h000);
        wr("R5", 5'h0C, 32'hFFFF_FFFF, 12'h000);
        rd("R5", 5'h00, 12'h000);

        // R7: priority between sources 9 and 3, then none
        rd("R7", 5'h18, 12'h208);
        rd("R7", 5'h18, 12'h200);
        wr("R7", 5'h0C, 32'h8, 12'h200);
        rd("R7", 5'h18, 12'h000);
        wr("R7", 5'h0C, 32'hFFFF_FFFF, 12'h000);
        rd("R7", 5'h18, 12'h000);

        // R6: writes to status, pending and vector ignored
        rd("R6", 5'h04, 12'h010);
        wr("R6", 5'h00, 32'h0, 12'h000);
        wr("R6", 5'h04, 32'h0, 12'h000);
        wr("R6", 5'h18, 32'h0, 12'h000);
        rd("R6", 5'h04, 12'h000);
        rd("R6", 5'h00, 12'h000);

        // R9: hardware enable off blocks the request
        wr("R9", 5'h1C, 32'h1, 12'h000);
        rd("R9", 5'h04, 12'h000);
        wr("R9", 5'h1C, 32'h3, 12'h000);
        rd("R9", 5'h04, 12'h000);
        wr("R9", 5'h14, 32'hFFFF_FFFF, 12'h000);
        rd("R9", 5'h04, 12'h000);

        // mixed traffic against the model
        lfsr = 16'hACE1;
        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cyc("R7", {lfsr[4:2], 2'b00}, lfsr[5] & lfsr[9],
                {lfsr, lfsr[15:8], lfsr[7:0]}, lfsr[11:0] ^ 12'(k));
        end

        finish_run();
    end

endmodule